// File: doc/BRIEF.md
# Gshare Branch Direction Predictor

This block predicts whether a conditional branch will be taken. A pattern table of 2-bit saturating counters is indexed by the word-aligned bits of the branch PC XORed with a global register that holds the outcomes of recent branches. The fetch stage presents a PC on the lookup port and receives a taken/not-taken prediction in the same cycle, combinationally.

After a branch resolves, the caller drives the update strobe together with the actual outcome and the branch PC. In that cycle the addressed counter is trained, and the outcome is shifted into the history. The caller pre-decodes instructions and raises the strobe only for conditional branches. Jumps, target lookup and next-PC selection are handled outside this block.

Top module: `gshare_pred`

## Requirements
- R1: While rst_ni is low and after it is released, every counter holds 2'b01 (weakly not-taken) and the history is all zeros. Until the first update, every lookup predicts not-taken.
- R2: The table index is lookup PC bits [IDX_W+1:2] XORed with the history, where IDX_W = log2(PHT_ENTRIES) and the history is IDX_W bits wide. PC bits [1:0] and the bits above IDX_W+1 have no effect on the result.
- R3: pred_taken_o equals bit 1 of the indexed counter (states 2'b10 and 2'b11 predict taken), and it follows lookup_pc_i in the same cycle.
- R4: An update with upd_taken_i=1 increments the counter selected by upd_pc_i and the current history, and the counter stays at 2'b11 once it is there.
- R5: An update with upd_taken_i=0 decrements the selected counter, and the counter stays at 2'b00 once it is there.
- R6: While upd_valid_i is low, no counter and no history bit changes, whatever upd_taken_i and upd_pc_i carry.
- R7: Each update shifts the history left by one bit and places the outcome in bit 0. The counter written in the same cycle is indexed with the history as it was before the shift.
- R8: When a lookup and an update address the same entry in the same cycle, the lookup returns the counter value from before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lookup_pc_i | input | PC_W | PC of the instruction being fetched |
| pred_taken_o | output | 1 | Predicted direction for lookup_pc_i |
| upd_valid_i | input | 1 | Update strobe for a resolved conditional branch |
| upd_taken_i | input | 1 | Actual outcome of the resolved branch |
| upd_pc_i | input | PC_W | PC of the resolved branch |

## Verification
Directed runs first sweep lookups right after reset. They then send long runs of the same outcome at one PC, which drives the counter into saturation at both ends and fills the history with all ones or all zeros. Alternating outcomes separate a correct history shift direction from a reversed one. Lookups that carry junk in the low and high PC bits show that only the index bits are used. Strobe-low cycles that carry a taken outcome must leave every later prediction unchanged, and lookups at the PC being updated separate the pre-update read from a write-through read. A seeded random phase draws from a small PC pool so that entries alias through the history XOR, and it compares every prediction against a bench reference table.

// File: rtl/gshare_pkg.sv
package gshare_pkg;
  typedef logic [1:0] ctr_t;
  localparam ctr_t CTR_MIN     = 2'b00;
  localparam ctr_t CTR_WEAK_NT = 2'b01;
  localparam ctr_t CTR_MAX     = 2'b11;
endpackage

// File: rtl/gshare_index.sv
module gshare_index #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 8
) (
  input  logic [PC_W-1:0]  pc_i,
  input  logic [IDX_W-1:0] hist_i,
  output logic [IDX_W-1:0] idx_o
);
  // word-aligned PC bits, low two dropped
  assign idx_o = pc_i[IDX_W+1:2] ^ hist_i;
endmodule

// File: rtl/gshare_hist.sv
module gshare_hist #(
  parameter int HIST_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic [HIST_W-1:0] hist_o
);
  logic [HIST_W-1:0] hist_d;

  generate
    if (HIST_W > 1) begin : g_wide
      assign hist_d = {hist_o[HIST_W-2:0], bit_i};
    end else begin : g_one
      assign hist_d = bit_i;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hist_o <= '0;
    else if (shift_i) hist_o <= hist_d;
  end
endmodule

// File: rtl/gshare_ctr_step.sv
module gshare_ctr_step
  import gshare_pkg::*;
(
  input  ctr_t cur_i,
  input  logic taken_i,
  output ctr_t nxt_o
);
  always_comb begin
    nxt_o = cur_i;
    if (taken_i) begin
      if (cur_i != CTR_MAX) nxt_o = cur_i + 2'd1;
    end else begin
      if (cur_i != CTR_MIN) nxt_o = cur_i - 2'd1;
    end
  end
endmodule

// File: rtl/gshare_pht.sv
module gshare_pht
  import gshare_pkg::*;
#(
  parameter int ENTRIES = 256,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] lk_idx_i,
  output ctr_t             lk_ctr_o,
  input  logic [IDX_W-1:0] up_idx_i,
  output ctr_t             up_ctr_o,
  input  logic             wr_en_i,
  input  ctr_t             wr_ctr_i
);
  ctr_t tbl_q [ENTRIES];

  // reads see the stored value; writes land at the edge
  assign lk_ctr_o = tbl_q[lk_idx_i];
  assign up_ctr_o = tbl_q[up_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) tbl_q[i] <= CTR_WEAK_NT;
    end else if (wr_en_i) begin
      tbl_q[up_idx_i] <= wr_ctr_i;
    end
  end
endmodule

// File: rtl/gshare_pred.sv
module gshare_pred
  import gshare_pkg::*;
#(
  parameter int PHT_ENTRIES = 256,
  parameter int PC_W        = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] lookup_pc_i,
  output logic            pred_taken_o,
  input  logic            upd_valid_i,
  input  logic            upd_taken_i,
  input  logic [PC_W-1:0] upd_pc_i
);
  localparam int IDX_W = $clog2(PHT_ENTRIES);

  logic [IDX_W-1:0] hist_q;
  logic [IDX_W-1:0] lk_idx;
  logic [IDX_W-1:0] up_idx;
  ctr_t             lk_ctr;
  ctr_t             upd_ctr;
  ctr_t             nxt_ctr;

  gshare_index #(.PC_W(PC_W), .IDX_W(IDX_W)) u_lk_idx (
    .pc_i(lookup_pc_i), .hist_i(hist_q), .idx_o(lk_idx)
  );

  // update index uses pre-shift history
  gshare_index #(.PC_W(PC_W), .IDX_W(IDX_W)) u_up_idx (
    .pc_i(upd_pc_i), .hist_i(hist_q), .idx_o(up_idx)
  );

  gshare_pht #(.ENTRIES(PHT_ENTRIES)) u_pht (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lk_idx_i (lk_idx),
    .lk_ctr_o (lk_ctr),
    .up_idx_i (up_idx),
    .up_ctr_o (upd_ctr),
    .wr_en_i  (upd_valid_i),
    .wr_ctr_i (nxt_ctr)
  );

  gshare_ctr_step u_step (
    .cur_i(upd_ctr), .taken_i(upd_taken_i), .nxt_o(nxt_ctr)
  );

  gshare_hist #(.HIST_W(IDX_W)) u_hist (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (upd_valid_i),
    .bit_i   (upd_taken_i),
    .hist_o  (hist_q)
  );

  assign pred_taken_o = lk_ctr[1];
endmodule

// File: rtl/gshare_pred_chk.sv
module gshare_pred_chk #(
  parameter int HIST_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              upd_valid_i,
  input logic              upd_taken_i,
  input logic [HIST_W-1:0] hist_i,
  input logic [1:0]        cur_ctr_i,
  input logic [1:0]        nxt_ctr_i
);
  // R7
  hist_shift_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i |=> hist_i[0] == $past(upd_taken_i));

  // R6
  hist_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_valid_i |=> $stable(hist_i));

  // R4
  ctr_sat_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_taken_i && cur_ctr_i == 2'b11) |-> nxt_ctr_i == 2'b11);

  // R4
  ctr_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_taken_i && cur_ctr_i != 2'b11) |-> nxt_ctr_i == cur_ctr_i + 2'd1);

  // R5
  ctr_sat_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && !upd_taken_i && cur_ctr_i == 2'b00) |-> nxt_ctr_i == 2'b00);

  // R5
  ctr_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && !upd_taken_i && cur_ctr_i != 2'b00) |-> nxt_ctr_i == cur_ctr_i - 2'd1);
endmodule

bind gshare_pred gshare_pred_chk #(.HIST_W(IDX_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .upd_valid_i (upd_valid_i),
  .upd_taken_i (upd_taken_i),
  .hist_i      (hist_q),
  .cur_ctr_i   (upd_ctr),
  .nxt_ctr_i   (nxt_ctr)
);

// File: tb/sim_gshare_pred.sv
`timescale 1ns/1ps
module sim_gshare_pred;
  localparam int ENT = 256;
  localparam int PW  = 32;
  localparam int IW  = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [PW-1:0] lk_pc = '0;
  logic          pred;
  logic          uv = 1'b0;
  logic          ut = 1'b0;
  logic [PW-1:0] up_pc = '0;

  int checks = 0;
  int fails = 0;
  logic [1:0]    mdl [ENT];
  logic [IW-1:0] mh;

  always #10 clk = ~clk;

  gshare_pred #(.PHT_ENTRIES(ENT), .PC_W(PW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .lookup_pc_i(lk_pc), .pred_taken_o(pred),
    .upd_valid_i(uv), .upd_taken_i(ut), .upd_pc_i(up_pc)
  );

  function automatic logic [IW-1:0] idx_of(logic [PW-1:0] pc, logic [IW-1:0] h);
    return pc[IW+1:2] ^ h;
  endfunction

  function automatic logic [1:0] train(logic [1:0] c, logic t);
    if (t) return (c == 2'b11) ? c : c + 2'd1;
    return (c == 2'b00) ? c : c - 2'd1;
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: pred_taken_o=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < ENT; i++) mdl[i] = 2'b01;
    mh = '0;
  endtask

  task automatic step(logic [PW-1:0] pc, logic v, logic t, logic [PW-1:0] upc, string tag);
    @(negedge clk);
    lk_pc = pc; uv = v; ut = t; up_pc = upc;
    #1;
    chk(tag, pred, mdl[idx_of(pc, mh)][1]);
    @(posedge clk);
    if (v) begin
      mdl[idx_of(upc, mh)] = train(mdl[idx_of(upc, mh)], t);
      mh = {mh[IW-2:0], t};
    end
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [PW-1:0] pc_a;
    logic [PW-1:0] pool [16];
    void'($urandom(32'd1234));
    model_reset();
    repeat (2) @(posedge clk);
    // R1: during reset every lookup predicts not-taken
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      lk_pc = i * 36;
      #1 chk("R1", pred, 1'b0);
    end
    @(negedge clk) rst_n = 1'b1;
    // R1: after release, all entries weakly not-taken
    for (int i = 0; i < ENT; i += 17) step(i << 2, 1'b0, 1'b0, '0, "R1");

    // R8: lookup of the entry being updated sees the old value
    pc_a = 32'h0000_0140;
    for (int i = 0; i < 6; i++) step(pc_a, 1'b1, 1'b1, pc_a, "R8");

    // R4: repeated taken pushes counters to saturation
    for (int i = 0; i < 14; i++) step(pc_a, 1'b1, 1'b1, pc_a, "R4");
    for (int i = 0; i < 4; i++) step(pc_a, 1'b0, 1'b0, '0, "R4");

    // R2: low two bits and upper bits ignored
    step(pc_a | 32'h3, 1'b0, 1'b0, '0, "R2");
    step(pc_a | 32'hFFF0_0000, 1'b0, 1'b0, '0, "R2");
    step(pc_a ^ 32'h0000_0004, 1'b0, 1'b0, '0, "R2");

    // R6: strobe low with taken outcome changes nothing
    for (int i = 0; i < 20; i++) step(pc_a, 1'b0, 1'b1, pc_a, "R6");
    for (int i = 0; i < ENT; i += 5) step(i << 2, 1'b0, 1'b0, '0, "R6");

    // R5: repeated not-taken drains to zero and holds
    for (int i = 0; i < 14; i++) step(pc_a, 1'b1, 1'b0, pc_a, "R5");

    // R7: alternating outcomes expose history shift direction
    for (int i = 0; i < 40; i++) step(32'h200 + ((i % 3) << 2), 1'b1, i[0], 32'h200, "R7");
    for (int i = 0; i < 32; i++) step(32'h200 + (i << 2), 1'b0, 1'b0, '0, "R7");

    // R3: random mix over an aliasing PC pool
    for (int i = 0; i < 16; i++) pool[i] = $urandom & 32'hFFFF_FFFC | ($urandom & 3);
    for (int i = 0; i < 3000; i++) begin
      logic v;
      v = ($urandom % 10) < 7;
      step(pool[$urandom % 16], v, $urandom % 3 != 0, pool[$urandom % 16], "R3");
    end

    // R1: reset again in mid-run
    @(negedge clk) rst_n = 1'b0;
    model_reset();
    @(negedge clk) rst_n = 1'b1;
    for (int i = 0; i < 16; i++) step(pool[i], 1'b0, 1'b0, '0, "R1");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule